// File: doc/BRIEF.md
# Residue-Log Multiply/Divide Unit

This unit multiplies or divides two signed numbers held in residue-logarithmic form. An operand is a zero flag, a sign bit, and the base-2 logarithm of its magnitude. The logarithm is not held as a binary integer. It is held as three residues, taken modulo 3, 4 and 5, and each residue is a one-hot wire group. Because a product of magnitudes is a sum of logarithms, a multiply becomes three independent modular additions. A divide becomes three modular subtractions. On one-hot groups each of these is a fixed rotation network, and no multiplier array is needed. The sign of the result is the exclusive-OR of the operand signs.

A caller presents both operands and an operation select with `in_valid` high. The result appears on the registered outputs one clock later, marked by `out_valid`. Multiplying by zero gives zero. Dividing by a zero divisor raises an error flag. Three steps stay outside the unit: conversion into the log form, log-domain addition, and conversion back to binary. The moduli are parameters, checked at elaboration to be at least 2 and pairwise coprime. A parameter also chooses how the divide path is built.

Top module: `rlns_muldiv`

## Requirements
- R1: With `op_div`=0 and both zero flags low, each result channel equals (a + b) mod m. The log bus puts the modulo-3 channel on bits [2:0], the modulo-4 channel on bits [6:3] and the modulo-5 channel on bits [11:7]. Within a channel, bit k set means residue k, and exactly one bit is set.
- R2: With `op_div`=1 and both zero flags low, each result channel equals (a - b) mod m, wrapped into the range 0..m-1, in the layout of R1.
- R3: When the result is not zero, `r_sign` equals `a_sign` XOR `b_sign`.
- R4: A multiply with either zero flag high gives `r_zero`=1, `r_sign`=0 and `div_by_zero`=0. It also gives `r_log` = 12'h089, which is residue 0 in every channel.
- R5: A divide with `b_zero` high gives `div_by_zero`=1, `r_zero`=1, `r_sign`=0 and `r_log` = 12'h089, whatever the first operand holds.
- R6: A divide with `a_zero` high and `b_zero` low gives `r_zero`=1, `div_by_zero`=0, `r_sign`=0 and `r_log` = 12'h089.
- R7: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high. It is low in the cycle after an edge that samples `in_valid` low.
- R8: A clock edge that samples `in_valid` low leaves `r_zero`, `r_sign`, `r_log` and `div_by_zero` unchanged.
- R9: Asynchronous reset, active low, sets `out_valid`=0, `r_zero`=1, `r_sign`=0, `div_by_zero`=0 and `r_log` = 12'h089.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation are presented |
| op_div | input | 1 | 0 = multiply, 1 = divide (a / b) |
| a_zero | input | 1 | First operand is zero |
| a_sign | input | 1 | First operand is negative |
| a_log | input | 12 | First operand log residues, one-hot per channel |
| b_zero | input | 1 | Second operand is zero |
| b_sign | input | 1 | Second operand is negative |
| b_log | input | 12 | Second operand log residues, one-hot per channel |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| r_zero | output | 1 | Result is zero |
| r_sign | output | 1 | Result is negative |
| r_log | output | 12 | Result log residues, one-hot per channel |
| div_by_zero | output | 1 | The last divide had a zero divisor |

## Verification
The bench drives negative log values and log differences that wrap past a modulus. In those cases a rotation network turned the wrong way, or a divide that reuses the add path, produces residues that are off in one channel only. It drives every combination of zero flags on both operations, including zero divided by zero. A unit that checked the wrong operand, or let the dividend's zero hide the divisor error, would then report the wrong flag or leave the error flag low. Idle cycles carry changing operands, so a result register that loads without `in_valid` shows new values. A reset in the middle of the run must restore the fixed reset pattern.

// File: rtl/rlns_pkg.sv
package rlns_pkg;

   typedef struct packed {
      logic zero;
      logic sign;
      logic dbz;
   } rlns_flags_t;

   // greatest common divisor, used for elaboration checks on the moduli
   function automatic int gcd(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

endpackage

// File: rtl/rlns_oh_neg.sv
// One-hot additive inverse modulo M: residue k maps to (M-k) mod M.
// Pure wiring, no gates.
module rlns_oh_neg #(
   parameter int M = 4
) (
   input  logic [M-1:0] din,
   output logic [M-1:0] dout
);
   for (genvar k = 0; k < M; k++) begin : g_bit
      assign dout[k] = din[(M - k) % M];
   end
endmodule

// File: rtl/rlns_oh_rot.sv
// One-hot modular sum: y = (a + b) mod M as an AND-OR crossbar.
module rlns_oh_rot #(
   parameter int M = 4
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] y
);
   for (genvar k = 0; k < M; k++) begin : g_out
      logic [M-1:0] term;
      for (genvar j = 0; j < M; j++) begin : g_in
         assign term[j] = a[j] & b[(k - j + M) % M];
      end
      assign y[k] = |term;
   end
endmodule

// File: rtl/rlns_chan.sv
// One residue channel: sum or difference of two one-hot residues.
// DIV_STYLE 0: invert the divisor by wiring, then share one crossbar.
// DIV_STYLE 1: two crossbars in parallel, select the result.
module rlns_chan #(
   parameter int M         = 4,
   parameter int DIV_STYLE = 0
) (
   input  logic         sub,
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] y
);
   logic [M-1:0] b_neg;

   rlns_oh_neg #(.M(M)) u_neg (.din(b), .dout(b_neg));

   if (DIV_STYLE == 0) begin : g_shared
      logic [M-1:0] b_sel;
      assign b_sel = sub ? b_neg : b;
      rlns_oh_rot #(.M(M)) u_rot (.a(a), .b(b_sel), .y(y));
   end else begin : g_dual
      logic [M-1:0] y_sum;
      logic [M-1:0] y_dif;
      rlns_oh_rot #(.M(M)) u_rot_add (.a(a), .b(b),     .y(y_sum));
      rlns_oh_rot #(.M(M)) u_rot_sub (.a(a), .b(b_neg), .y(y_dif));
      assign y = sub ? y_dif : y_sum;
   end

   // legal one-hot operands must give a one-hot residue (R1, R2)
   always_comb begin
      if ($onehot(a) && $onehot(b)) begin
         p_chan_onehot_r1: assert ($onehot(y));
      end
   end
endmodule

// File: rtl/rlns_flags.sv
// Sign, zero and divide-error resolution for one operation.
module rlns_flags
   import rlns_pkg::*;
(
   input  logic        op_div,
   input  logic        a_zero,
   input  logic        a_sign,
   input  logic        b_zero,
   input  logic        b_sign,
   output rlns_flags_t flags
);
   always_comb begin
      flags.dbz  = op_div & b_zero;
      flags.zero = a_zero | b_zero;
      flags.sign = flags.zero ? 1'b0 : (a_sign ^ b_sign);
   end
endmodule

// File: rtl/rlns_muldiv.sv
// Residue-log multiply/divide with one registered stage.
module rlns_muldiv
   import rlns_pkg::*;
#(
   parameter int M0        = 3,
   parameter int M1        = 4,
   parameter int M2        = 5,
   parameter int DIV_STYLE = 0,
   localparam int LW       = M0 + M1 + M2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          op_div,
   input  logic          a_zero,
   input  logic          a_sign,
   input  logic [LW-1:0] a_log,
   input  logic          b_zero,
   input  logic          b_sign,
   input  logic [LW-1:0] b_log,
   output logic          out_valid,
   output logic          r_zero,
   output logic          r_sign,
   output logic [LW-1:0] r_log,
   output logic          div_by_zero
);
   localparam int NCH = 3;
   localparam logic [LW-1:0] ZPAT =
      LW'(1) | (LW'(1) << M0) | (LW'(1) << (M0 + M1));

   // elaboration-time parameter checks
   if (M0 < 2 || M1 < 2 || M2 < 2) begin : g_chk_min
      $error("rlns_muldiv: every modulus must be at least 2");
   end
   if (gcd(M0, M1) != 1 || gcd(M0, M2) != 1 || gcd(M1, M2) != 1) begin : g_chk_cop
      $error("rlns_muldiv: moduli must be pairwise coprime");
   end
   if (DIV_STYLE != 0 && DIV_STYLE != 1) begin : g_chk_style
      $error("rlns_muldiv: DIV_STYLE must be 0 or 1");
   end

   logic [LW-1:0] log_d;
   rlns_flags_t   flg_d;
   rlns_flags_t   flg_q;
   logic [LW-1:0] log_q;
   logic          vld_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int MC = (c == 0) ? M0 : (c == 1) ? M1 : M2;
      localparam int OC = (c == 0) ? 0  : (c == 1) ? M0 : M0 + M1;
      rlns_chan #(.M(MC), .DIV_STYLE(DIV_STYLE)) u_chan (
         .sub (op_div),
         .a   (a_log[OC +: MC]),
         .b   (b_log[OC +: MC]),
         .y   (log_d[OC +: MC])
      );
   end

   rlns_flags u_flags (
      .op_div (op_div),
      .a_zero (a_zero),
      .a_sign (a_sign),
      .b_zero (b_zero),
      .b_sign (b_sign),
      .flags  (flg_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         flg_q <= '{zero: 1'b1, sign: 1'b0, dbz: 1'b0};
         log_q <= ZPAT;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            flg_q <= flg_d;
            log_q <= flg_d.zero ? ZPAT : log_d;
         end
      end
   end

   assign out_valid   = vld_q;
   assign r_zero      = flg_q.zero;
   assign r_sign      = flg_q.sign;
   assign div_by_zero = flg_q.dbz;
   assign r_log       = log_q;

   p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |->
         ($stable(r_log) && $stable(r_zero) && $stable(r_sign) && $stable(div_by_zero)));

   p_sign_xor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid && !r_zero) |->
         (r_sign == ($past(a_sign) ^ $past(b_sign))));

   p_dbz_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid && div_by_zero) |-> ($past(op_div) && $past(b_zero)));

   p_zero_pat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      r_zero |-> ((r_log == ZPAT) && !r_sign));

   p_mul_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && !$past(op_div) && ($past(a_zero) || $past(b_zero)))
         |-> (r_zero && !div_by_zero));
endmodule

// File: tb/sim_rlns_muldiv.sv
module sim_rlns_muldiv;
   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic        op_div;
   logic        a_zero;
   logic        a_sign;
   logic [11:0] a_log;
   logic        b_zero;
   logic        b_sign;
   logic [11:0] b_log;
   logic        out_valid;
   logic        r_zero;
   logic        r_sign;
   logic [11:0] r_log;
   logic        div_by_zero;

   int n_chk  = 0;
   int n_fail = 0;

   rlns_muldiv u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_div(op_div),
      .a_zero(a_zero), .a_sign(a_sign), .a_log(a_log),
      .b_zero(b_zero), .b_sign(b_sign), .b_log(b_log),
      .out_valid(out_valid), .r_zero(r_zero), .r_sign(r_sign),
      .r_log(r_log), .div_by_zero(div_by_zero)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   // residues of an integer log, one-hot, layout [2:0] mod3, [6:3] mod4, [11:7] mod5
   function automatic logic [11:0] enc(input int l);
      logic [11:0] v;
      v = '0;
      v[((l % 3) + 3) % 3]     = 1'b1;
      v[3 + ((l % 4) + 4) % 4] = 1'b1;
      v[7 + ((l % 5) + 5) % 5] = 1'b1;
      return v;
   endfunction

   function automatic logic [14:0] pack_out();
      return {r_zero, r_sign, div_by_zero, r_log};
   endfunction

   task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // present one operation at a negedge, check the result one cycle later
   task automatic run_op(input string req, input logic div, input logic az, input logic as_,
                         input int la, input logic bz, input logic bs, input int lb);
      logic [14:0] exp;
      logic        ez;
      logic        edz;
      ez  = az | bz;
      edz = div & bz;
      if (ez) exp = {1'b1, 1'b0, edz, 12'h089};
      else    exp = {1'b0, as_ ^ bs, 1'b0, div ? enc(la - lb) : enc(la + lb)};
      in_valid = 1'b1;
      op_div   = div;
      a_zero   = az;  a_sign = as_; a_log = enc(la);
      b_zero   = bz;  b_sign = bs;  b_log = enc(lb);
      @(negedge clk);
      check("R7 out_valid after accepted op", {14'd0, out_valid}, 15'd1);
      check(req, pack_out(), exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R7: watchdog got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [14:0] prev;
      void'($urandom(32'h1CE5EED));
      rst_n = 1'b0; in_valid = 1'b0; op_div = 1'b0;
      a_zero = 1'b0; a_sign = 1'b0; a_log = enc(0);
      b_zero = 1'b0; b_sign = 1'b0; b_log = enc(0);
      repeat (3) @(negedge clk);
      check("R9 reset out_valid", {14'd0, out_valid}, 15'd0);
      check("R9 reset fields", pack_out(), {1'b1, 1'b0, 1'b0, 12'h089});
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 idle after reset", {14'd0, out_valid}, 15'd0);

      // directed: identity, wrap, negative logs
      run_op("R1 mul 0+0",           1'b0, 1'b0, 1'b0, 0,   1'b0, 1'b0, 0);
      run_op("R1 mul wrap 2+4",      1'b0, 1'b0, 1'b0, 2,   1'b0, 1'b0, 4);
      run_op("R1 mul negative",      1'b0, 1'b0, 1'b1, -7,  1'b0, 1'b0, -13);
      run_op("R2 div 3-7 wraps",     1'b1, 1'b0, 1'b0, 3,   1'b0, 1'b1, 7);
      run_op("R2 div x/x",           1'b1, 1'b0, 1'b1, 11,  1'b0, 1'b1, 11);
      run_op("R3 sign mixed",        1'b0, 1'b0, 1'b1, 5,   1'b0, 1'b0, 9);
      run_op("R4 mul a zero",        1'b0, 1'b1, 1'b1, 4,   1'b0, 1'b0, 6);
      run_op("R4 mul b zero",        1'b0, 1'b0, 1'b0, 4,   1'b1, 1'b1, 6);
      run_op("R4 mul both zero",     1'b0, 1'b1, 1'b0, 1,   1'b1, 1'b0, 2);
      run_op("R5 div by zero",       1'b1, 1'b0, 1'b1, 8,   1'b1, 1'b0, 3);
      run_op("R5 div zero by zero",  1'b1, 1'b1, 1'b0, 8,   1'b1, 1'b1, 3);
      run_op("R6 div zero dividend", 1'b1, 1'b1, 1'b1, 2,   1'b0, 1'b1, 9);
      run_op("R2 div after error",   1'b1, 1'b0, 1'b0, -1,  1'b0, 1'b0, 59);

      // constrained random
      for (int i = 0; i < 400; i++) begin
         int  la;
         int  lb;
         logic dv;
         la = int'($urandom_range(120)) - 60;
         lb = int'($urandom_range(120)) - 60;
         dv = 1'($urandom_range(1));
         run_op(dv ? "R2 random div" : "R1 random mul", dv,
                ($urandom_range(7) == 0), 1'($urandom_range(1)), la,
                ($urandom_range(7) == 0), 1'($urandom_range(1)), lb);
      end

      // idle cycles with changing inputs must hold the result
      prev = pack_out();
      for (int i = 0; i < 4; i++) begin
         in_valid = 1'b0;
         op_div   = 1'($urandom_range(1));
         a_zero   = 1'($urandom_range(1));
         b_zero   = 1'($urandom_range(1));
         a_sign   = 1'($urandom_range(1));
         b_sign   = 1'($urandom_range(1));
         a_log    = enc(int'($urandom_range(30)));
         b_log    = enc(int'($urandom_range(30)));
         @(negedge clk);
         check("R7 no valid when idle", {14'd0, out_valid}, 15'd0);
         check("R8 result held when idle", pack_out(), prev);
      end

      // reset in the middle of activity
      run_op("R1 mul before reset", 1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b0, 1);
      rst_n = 1'b0;
      #1;
      check("R9 mid-run reset out_valid", {14'd0, out_valid}, 15'd0);
      check("R9 mid-run reset fields", pack_out(), {1'b1, 1'b0, 1'b0, 12'h089});
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_op("R2 div after reset", 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b1, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule